// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block converts one DMA channel's transfer settings into a series of bus accesses. Software-facing logic elsewhere loads a unit size, a bus-holding mode and a number of units to move. The sequencer then asks the bus arbiter for the bus, issues accesses with a size code and an address step, waits for each access to be acknowledged, and counts units down to zero. It raises a one-cycle end pulse when the last unit finishes.

Unit sizes of one, two and four bytes map to a single access each. A sixteen-byte unit is carried out as four longword accesses in a row, and the bus is never given up between them. In cycle-steal mode the bus is given back after every unit, and a fresh transfer request is needed before the next unit. In burst mode the bus is kept until the count runs out. When the request comes from an on-chip peripheral and the count mode bit is clear, burst is not allowed, and the sequencer behaves as in cycle-steal mode.

Top module: `dma_seq_top`

## Requirements
- R1: During and right after a synchronous reset, bus_req, acc_valid and eot are 0 and cnt_left is 0.
- R2: For unit size codes 00 (byte), 01 (word) and 10 (longword), each unit is one access with acc_size equal to the size code and acc_incr equal to 1, 2 or 4.
- R3: Unit size code 11 gives four accesses per unit, each with acc_size 10 and acc_incr 4, and bus_req stays high across all four, even in cycle-steal mode.
- R4: In cycle-steal mode (cfg_burst 0), bus_req drops in the cycle after a unit completes. xfer_req is sampled only while the sequencer is idle, so a request raised during an access is ignored, and a later one starts the next unit.
- R5: In burst mode (cfg_burst 1), bus_req rises once and stays high until the count reaches zero, with no further xfer_req.
- R6: When cfg_periph is 1 and cfg_cnt_mode is 0, the sequencer uses cycle-steal behaviour whatever cfg_burst says. With cfg_cnt_mode 1, burst is honoured.
- R7: While acc_valid is high and acc_ready is low, acc_valid, acc_size and acc_incr hold their values.
- R8: cnt_left drops by one per completed unit. eot is a single-cycle pulse in the cycle where cnt_left becomes 0, and bus_req is low in that same cycle.
- R9: acc_valid rises only in the cycle after bus_gnt was seen high while bus_req was high.
- R10: With cnt_left equal to 0, xfer_req does not raise bus_req.
- R11: load is accepted only while idle. It sets cnt_left to load_cnt and captures the cfg_* inputs for the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load count and settings (idle only) |
| load_cnt | input | CNT_W | Number of units to transfer |
| cfg_size | input | 2 | Unit size code: 00 byte, 01 word, 10 longword, 11 sixteen-byte |
| cfg_burst | input | 1 | 0 cycle-steal, 1 burst |
| cfg_periph | input | 1 | Request source is an on-chip peripheral |
| cfg_cnt_mode | input | 1 | Transfer count mode bit |
| xfer_req | input | 1 | Transfer request, sampled when idle |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| acc_valid | output | 1 | Access request valid |
| acc_size | output | 2 | Access size code: 00 byte, 01 word, 10 longword |
| acc_incr | output | 3 | Address step in bytes for this access |
| acc_ready | input | 1 | Access completed by the bus |
| cnt_left | output | CNT_W | Units still to transfer |
| eot | output | 1 | End-of-transfer pulse |

## Verification
The end of a unit and a new transfer request can land in the same clock cycle. The bench provokes this by raising xfer_req in the very cycle it gives acc_ready for the last access of a cycle-steal unit. It then checks that the bus is released and stays released until a later request arrives. The final access of the final unit also makes the count reach zero, raise eot and release the bus all on one edge. Every table vector checks this through the eot count, the bus_req rise count and the final cnt_left.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_LINE = 2'b11
  } unit_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ARB  = 2'b01,
    ST_XFER = 2'b10
  } seq_state_e;

  localparam int unsigned INC_W      = 3;
  localparam int unsigned BEAT_W     = 2;
  localparam int unsigned LINE_BEATS = 4;
endpackage

// File: rtl/dma_seq_decode.sv
module dma_seq_decode
  import dma_seq_pkg::*;
#(
  parameter int unsigned IW = INC_W,
  parameter int unsigned BW = BEAT_W
) (
  input  unit_size_e      size,
  output logic [1:0]      code,
  output logic [IW-1:0]   incr,
  output logic [BW-1:0]   last_beat
);
  always_comb begin
    code      = 2'b10;
    incr      = IW'(4);
    last_beat = '0;
    case (size)
      SZ_BYTE: begin code = 2'b00; incr = IW'(1); end
      SZ_WORD: begin code = 2'b01; incr = IW'(2); end
      SZ_LONG: begin code = 2'b10; incr = IW'(4); end
      SZ_LINE: begin
        code      = 2'b10;
        incr      = IW'(4);
        last_beat = BW'(LINE_BEATS - 1);
      end
      default: begin code = 2'b10; incr = IW'(4); end
    endcase
  end
endmodule

// File: rtl/dma_seq_count.sv
module dma_seq_count #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          is_zero,
  output logic          is_one
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld) begin
      cnt_q <= ld_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int unsigned BW = BEAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          bus_gnt,
  input  logic          acc_ready,
  input  logic          hold_bus,
  input  logic [BW-1:0] last_beat,
  input  logic          cnt_zero,
  input  logic          cnt_one,
  output logic          bus_req,
  output logic          acc_valid,
  output logic          eot,
  output logic          unit_done,
  output logic          idle
);
  seq_state_e    st_q;
  logic [BW-1:0] beat_q;
  logic          req_q, vld_q, eot_q;
  logic          beat_done;

  assign beat_done = (st_q == ST_XFER) && acc_ready;
  assign unit_done = beat_done && (beat_q == last_beat);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      req_q  <= 1'b0;
      vld_q  <= 1'b0;
      eot_q  <= 1'b0;
    end else begin
      eot_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start && !cnt_zero) begin
            st_q  <= ST_ARB;
            req_q <= 1'b1;
          end
        end
        ST_ARB: begin
          if (bus_gnt) begin
            st_q   <= ST_XFER;
            vld_q  <= 1'b1;
            beat_q <= '0;
          end
        end
        ST_XFER: begin
          if (beat_done) begin
            if (beat_q != last_beat) begin
              beat_q <= beat_q + 1'b1;
            end else if (cnt_one) begin
              st_q  <= ST_IDLE;
              req_q <= 1'b0;
              vld_q <= 1'b0;
              eot_q <= 1'b1;
            end else if (hold_bus) begin
              beat_q <= '0;
            end else begin
              st_q  <= ST_IDLE;
              req_q <= 1'b0;
              vld_q <= 1'b0;
            end
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          req_q <= 1'b0;
          vld_q <= 1'b0;
        end
      endcase
    end
  end

  assign bus_req   = req_q;
  assign acc_valid = vld_q;
  assign eot       = eot_q;
  assign idle      = (st_q == ST_IDLE);
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
  import dma_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic [1:0]       cfg_size,
  input  logic             cfg_burst,
  input  logic             cfg_periph,
  input  logic             cfg_cnt_mode,
  input  logic             xfer_req,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             acc_valid,
  output logic [1:0]       acc_size,
  output logic [INC_W-1:0] acc_incr,
  input  logic             acc_ready,
  output logic [CNT_W-1:0] cnt_left,
  output logic             eot
);
  unit_size_e        size_q;
  logic              hold_q;
  logic              idle, load_ok, unit_done, cnt_zero, cnt_one;
  logic [BEAT_W-1:0] last_beat;

  assign load_ok = load && idle;

  // Settings captured once per transfer; burst override resolved here.
  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= SZ_BYTE;
      hold_q <= 1'b0;
    end else if (load_ok) begin
      size_q <= unit_size_e'(cfg_size);
      hold_q <= cfg_burst && !(cfg_periph && !cfg_cnt_mode);
    end
  end

  dma_seq_decode #(.IW(INC_W), .BW(BEAT_W)) u_dec (
    .size      (size_q),
    .code      (acc_size),
    .incr      (acc_incr),
    .last_beat (last_beat)
  );

  dma_seq_count #(.CW(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ld      (load_ok),
    .ld_val  (load_cnt),
    .dec     (unit_done),
    .cnt     (cnt_left),
    .is_zero (cnt_zero),
    .is_one  (cnt_one)
  );

  dma_seq_fsm #(.BW(BEAT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (xfer_req && !load),
    .bus_gnt   (bus_gnt),
    .acc_ready (acc_ready),
    .hold_bus  (hold_q),
    .last_beat (last_beat),
    .cnt_zero  (cnt_zero),
    .cnt_one   (cnt_one),
    .bus_req   (bus_req),
    .acc_valid (acc_valid),
    .eot       (eot),
    .unit_done (unit_done),
    .idle      (idle)
  );
endmodule

// File: rtl/dma_seq_check.sv
module dma_seq_check
  import dma_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             acc_valid,
  input logic [1:0]       acc_size,
  input logic [INC_W-1:0] acc_incr,
  input logic             acc_ready,
  input logic [CNT_W-1:0] cnt_left,
  input logic             eot
);
  p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> (acc_size != 2'b11) && ($countones(acc_incr) == 1));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_ready) |=> acc_valid && $stable(acc_size) && $stable(acc_incr));

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt_left == $past(cnt_left)) || (cnt_left == $past(cnt_left) - 1'b1));

  p_eot_release_r8: assert property (@(posedge clk) disable iff (rst)
    eot |-> (cnt_left == '0) && !bus_req);

  p_eot_single_r8: assert property (@(posedge clk) disable iff (rst)
    eot |=> !eot);

  p_acc_owns_bus_r9: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> bus_req);

  p_after_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_valid) |-> $past(bus_gnt) && $past(bus_req));

  p_no_req_empty_r10: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (cnt_left != '0));
endmodule

bind dma_seq_top dma_seq_check #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .acc_valid (acc_valid),
  .acc_size  (acc_size),
  .acc_incr  (acc_incr),
  .acc_ready (acc_ready),
  .cnt_left  (cnt_left),
  .eot       (eot)
);

// File: tb/dma_seq_top_test.sv
module dma_seq_top_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst, load, cfg_burst, cfg_periph, cfg_cnt_mode, xfer_req;
  logic          bus_gnt, acc_ready;
  logic [CW-1:0] load_cnt;
  logic [1:0]    cfg_size;
  logic          bus_req, acc_valid, eot;
  logic [1:0]    acc_size;
  logic [2:0]    acc_incr;
  logic [CW-1:0] cnt_left;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dma_seq_top #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .load(load), .load_cnt(load_cnt),
    .cfg_size(cfg_size), .cfg_burst(cfg_burst), .cfg_periph(cfg_periph),
    .cfg_cnt_mode(cfg_cnt_mode), .xfer_req(xfer_req), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .acc_valid(acc_valid), .acc_size(acc_size),
    .acc_incr(acc_incr), .acc_ready(acc_ready), .cnt_left(cnt_left), .eot(eot)
  );

  // {size[31:30], burst[29], periph[28], cnt_mode[27], pad[26:24], units[23:16], accesses[15:8], bus_req rises[7:0]}
  localparam logic [31:0] VECS [0:7] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 8'd3, 8'd3,  8'd3},  // R2 R4 byte steal
    {2'd1, 1'b1, 1'b0, 1'b0, 3'd0, 8'd4, 8'd4,  8'd1},  // R2 R5 word burst
    {2'd2, 1'b0, 1'b0, 1'b0, 3'd0, 8'd2, 8'd2,  8'd2},  // R2 long steal
    {2'd3, 1'b0, 1'b0, 1'b0, 3'd0, 8'd2, 8'd8,  8'd2},  // R3 line steal
    {2'd3, 1'b1, 1'b0, 1'b0, 3'd0, 8'd3, 8'd12, 8'd1},  // R3 R5 line burst
    {2'd1, 1'b1, 1'b1, 1'b0, 3'd0, 8'd3, 8'd3,  8'd3},  // R6 forced steal
    {2'd2, 1'b1, 1'b1, 1'b1, 3'd0, 8'd3, 8'd3,  8'd1},  // R6 burst kept
    {2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 8'd2, 8'd2,  8'd1}   // R5 byte burst
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [1:0] sz, input logic b, input logic p,
                         input logic m, input int units);
    @(negedge clk);
    cfg_size = sz; cfg_burst = b; cfg_periph = p; cfg_cnt_mode = m;
    load_cnt = CW'(units); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_vec(input logic [31:0] v, input int idx);
    logic [1:0] sz, ecode;
    int units, eacc, erise, acc, rise, eots, badf;
    bit prev, phase;
    sz = v[31:30]; units = int'(v[23:16]); eacc = int'(v[15:8]); erise = int'(v[7:0]);
    ecode = (sz == 2'b11) ? 2'b10 : sz;
    acc = 0; rise = 0; eots = 0; badf = 0; prev = 1'b0; phase = 1'b0;
    do_load(sz, v[29], v[28], v[27], units);
    for (int c = 0; c < 2000; c++) begin
      if (bus_req && !prev) rise++;
      prev = bus_req;
      if (eot) eots++;
      if (eots > 0 && !bus_req) break;
      acc_ready = acc_valid && phase;
      if (acc_ready) begin
        acc++;
        if (acc_size != ecode || acc_incr != (3'd1 << ecode)) badf++;
      end
      phase = ~phase;
      bus_gnt = bus_req;
      xfer_req = !bus_req && (cnt_left != '0);
      @(negedge clk);
    end
    acc_ready = 1'b0; bus_gnt = 1'b0; xfer_req = 1'b0;
    chk(acc == eacc, $sformatf("R2/R3 vec%0d access count", idx), acc, eacc);
    chk(rise == erise, $sformatf("R4/R5/R6 vec%0d bus_req rises", idx), rise, erise);
    chk(eots == 1, $sformatf("R8 vec%0d eot pulses", idx), eots, 1);
    chk(cnt_left == '0, $sformatf("R8 vec%0d cnt_left end", idx), int'(cnt_left), 0);
    chk(badf == 0, $sformatf("R2/R3 vec%0d size/incr errors", idx), badf, 0);
  endtask

  initial begin
    logic [1:0] s0;
    logic [2:0] i0;
    rst = 1'b1; load = 1'b0; load_cnt = '0; cfg_size = 2'b00; cfg_burst = 1'b0;
    cfg_periph = 1'b0; cfg_cnt_mode = 1'b0; xfer_req = 1'b0; bus_gnt = 1'b0; acc_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bus_req && !acc_valid && !eot, "R1 outputs in reset", {bus_req, acc_valid, eot}, 0);
    chk(cnt_left == '0, "R1 cnt_left in reset", int'(cnt_left), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_req && !acc_valid && cnt_left == '0, "R1 after reset", int'(bus_req), 0);

    // R10: empty count ignores request
    do_load(2'b00, 1'b0, 1'b0, 1'b0, 0);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    chk(!bus_req, "R10 no request with zero count", int'(bus_req), 0);
    @(negedge clk);
    chk(!bus_req, "R10 still idle", int'(bus_req), 0);

    // R11 / R9 / R7: long steal, one unit, delayed grant and ready
    do_load(2'b10, 1'b0, 1'b0, 1'b0, 1);
    chk(cnt_left == CW'(1), "R11 count loaded", int'(cnt_left), 1);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    // R11: load while busy is refused
    load = 1'b1; load_cnt = CW'(9);
    @(negedge clk);
    load = 1'b0;
    chk(cnt_left == CW'(1), "R11 load ignored when busy", int'(cnt_left), 1);
    for (int k = 0; k < 4; k++) begin
      chk(bus_req && !acc_valid, "R9 no access before grant", int'(acc_valid), 0);
      @(negedge clk);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    chk(acc_valid, "R9 access after grant", int'(acc_valid), 1);
    s0 = acc_size; i0 = acc_incr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(acc_valid && acc_size == s0 && acc_incr == i0, "R7 held until ready",
          int'(acc_incr), int'(i0));
    end
    acc_ready = 1'b1;
    @(negedge clk);
    acc_ready = 1'b0;
    chk(eot && !bus_req && cnt_left == '0, "R8 eot with release", int'(eot), 1);
    @(negedge clk);
    chk(!eot, "R8 eot one cycle", int'(eot), 0);

    // R4: request coinciding with unit completion is not kept
    do_load(2'b00, 1'b0, 1'b0, 1'b0, 2);
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0; bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    acc_ready = 1'b1; xfer_req = 1'b1;
    @(negedge clk);
    acc_ready = 1'b0; xfer_req = 1'b0;
    chk(!bus_req && !acc_valid, "R4 bus released after unit", int'(bus_req), 0);
    chk(cnt_left == CW'(1), "R8 count after one unit", int'(cnt_left), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!bus_req, "R4 no re-request without xfer_req", int'(bus_req), 0);
    end
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    chk(bus_req, "R4 new request accepted", int'(bus_req), 1);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0; acc_ready = 1'b1;
    @(negedge clk);
    acc_ready = 1'b0;
    chk(eot && cnt_left == '0, "R8 final unit eot", int'(eot), 1);

    // table walk
    for (int i = 0; i < 8; i++) run_vec(VECS[i], i);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule